// File: doc/BRIEF.md
# Mode-Banked Processor Register File

This block is the architectural register store of a small 32-bit RISC core. Sixteen logical registers, a current status word and a saved status word are reached through a mapping that depends on the processor mode. The mode is held in the low five bits of the current status word. The same logical register number can therefore select different physical storage, depending on the mode in force. Behind the mapping sit 37 physical words: 30 general-purpose words, one program counter, one current status word and five saved status words, one for each exception mode.

The core reads two operands and writes one result in each cycle. A separate path reads and writes the status words. An exception-entry strobe carries out the one operation that the block sequences itself. In a single clock edge it saves the current status word into the saved status word of the target mode and switches the current mode to that target. Instruction decode, the ALU and the decision to take an exception all live outside this block.

Top module: `banked_regfile`

## Requirements
- R1: While reset is low and after it is released, every general-purpose word, the program counter and every saved status word read as zero, and the current status word reads 0x00000013 (Supervisor mode).
- R2: Mode codes are User 0x10, FIQ 0x11, IRQ 0x12, Supervisor 0x13, Abort 0x17, Undefined 0x1B and System 0x1F, taken from current status bits [4:0]. Any other code maps like User. Logical r0 to r7 are one physical set in all modes. Logical r8 to r12 are one physical set shared by every mode except FIQ.
- R3: In FIQ mode, logical r8 to r14 select seven words that no other mode can reach.
- R4: Logical r13 and r14 each have six physical copies: User/System, FIQ, IRQ, Supervisor, Abort and Undefined. User and System select the same copy.
- R5: Logical r15 is the program counter in every mode. A read of index 15 on either port returns `pc_out`. A write to index 15 appears on `pc_out` after the next rising edge.
- R6: The read ports are combinational. A write takes effect at the rising edge, so a read of the register being written in that cycle returns the old value.
- R7: A status write with `st_wr_saved` low replaces the whole current status word at the next edge, and this changes the active mode.
- R8: Each of FIQ, IRQ, Supervisor, Abort and Undefined has a private saved status word. A status write with `st_wr_saved` high reaches only the word of the current mode.
- R9: In User or System mode, a saved status read returns zero, a saved status write is discarded, and `spsr_fault` is high while either access is presented.
- R10: When `exc_en` is high at an edge, the saved status word of `exc_mode` receives the current status word, and current status bits [4:0] become `exc_mode` while bits [31:5] are kept. If `exc_mode` is User or System, only the mode changes.
- R11: If `exc_en` and a status write fall in the same cycle, the status write is dropped. A general-purpose write in that cycle lands in the bank of the mode in force before the edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_a_idx | input | 4 | Logical register number, read port A |
| rd_a_data | output | 32 | Read port A data |
| rd_b_idx | input | 4 | Logical register number, read port B |
| rd_b_data | output | 32 | Read port B data |
| wr_en | input | 1 | General register write enable |
| wr_idx | input | 4 | Logical register number to write |
| wr_data | input | 32 | General register write data |
| st_rd_saved | input | 1 | Status read selects saved (1) or current (0) word |
| st_rd_data | output | 32 | Status read data |
| st_wr_en | input | 1 | Status write enable |
| st_wr_saved | input | 1 | Status write targets saved (1) or current (0) word |
| st_wr_data | input | 32 | Status write data |
| exc_en | input | 1 | Exception-entry strobe |
| exc_mode | input | 5 | Mode entered on the strobe |
| pc_out | output | 32 | Program counter |
| cpsr_out | output | 32 | Current status word |
| spsr_fault | output | 1 | Saved status access in a mode that has none |

## Verification
Exception entry can fall in the same cycle as an ordinary write, either a general-register write or a status write, and that collision is the one worth provoking. The bench is in Abort mode when it raises `exc_en` towards Undefined. In the same cycle it drives a current status write and a write to r13. It then checks that the status word kept its flags and took only the new mode, that Undefined's saved word holds the old Abort status, and that the r13 value appears when the bench switches back to Abort but not in Undefined's r13.

// File: rtl/banked_rf_pkg.sv
package banked_rf_pkg;

  localparam int MODE_W    = 5;
  localparam int LOG_REGS  = 16;
  localparam int LOG_IDX_W = $clog2(LOG_REGS);
  localparam int SHARED_LO = 8;              // r0..r7 never banked
  localparam int FIQ_FIRST = 8;              // first register banked for FIQ
  localparam int SP_IDX    = 13;
  localparam int PC_IDX    = LOG_REGS - 1;
  localparam int NUM_BANKS = 6;
  localparam int NUM_SAVED = NUM_BANKS - 1;
  localparam int HI_SHARED = SP_IDX - FIQ_FIRST;             // r8..r12 count
  localparam int SP_BASE   = SHARED_LO + 2 * HI_SHARED;       // 18
  localparam int NUM_GPR   = SP_BASE + 2 * NUM_BANKS;         // 30
  localparam int GPR_IDX_W = $clog2(NUM_GPR);
  localparam int SLOT_W    = $clog2(NUM_SAVED);

  typedef enum logic [MODE_W-1:0] {
    MODE_USR = 5'h10,
    MODE_FIQ = 5'h11,
    MODE_IRQ = 5'h12,
    MODE_SVC = 5'h13,
    MODE_ABT = 5'h17,
    MODE_UND = 5'h1B,
    MODE_SYS = 5'h1F
  } mode_e;

  typedef enum logic [2:0] {
    BANK_USR = 3'd0,
    BANK_FIQ = 3'd1,
    BANK_IRQ = 3'd2,
    BANK_SVC = 3'd3,
    BANK_ABT = 3'd4,
    BANK_UND = 3'd5
  } bank_e;

  // Mode code to storage bank; unknown codes fall back to the User bank.
  function automatic bank_e bank_of(logic [MODE_W-1:0] m);
    case (m)
      MODE_FIQ: return BANK_FIQ;
      MODE_IRQ: return BANK_IRQ;
      MODE_SVC: return BANK_SVC;
      MODE_ABT: return BANK_ABT;
      MODE_UND: return BANK_UND;
      default:  return BANK_USR;
    endcase
  endfunction

  function automatic logic has_saved(bank_e b);
    return b != BANK_USR;
  endfunction

  function automatic logic [SLOT_W-1:0] saved_slot(bank_e b);
    return SLOT_W'(int'(b) - 1);
  endfunction

  // Logical number plus bank to physical general-purpose index.
  function automatic logic [GPR_IDX_W-1:0] gpr_phys(logic [LOG_IDX_W-1:0] idx, bank_e b);
    int i;
    i = int'(idx);
    if (i < SHARED_LO)
      return GPR_IDX_W'(i);
    else if (i < SP_IDX)
      return (b == BANK_FIQ) ? GPR_IDX_W'(i + HI_SHARED) : GPR_IDX_W'(i);
    else
      return GPR_IDX_W'(SP_BASE + 2 * int'(b) + (i - SP_IDX));
  endfunction

endpackage

// File: rtl/rf_bank_map.sv
module rf_bank_map
  import banked_rf_pkg::*;
(
  input  logic [LOG_IDX_W-1:0] idx,
  input  bank_e                bank,
  output logic [GPR_IDX_W-1:0] phys,
  output logic                 is_pc
);
  always_comb begin
    is_pc = (idx == LOG_IDX_W'(PC_IDX));
    phys  = is_pc ? '0 : gpr_phys(idx, bank);
  end
endmodule

// File: rtl/rf_saved_bank.sv
module rf_saved_bank
  import banked_rf_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int SLOTS  = NUM_SAVED,
  localparam int SW    = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SW-1:0]     wr_slot,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [SW-1:0]     rd_slot,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] word_q [SLOTS];

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n)
        word_q[s] <= '0;
      else if (wr_en && (wr_slot == SW'(s)))
        word_q[s] <= wr_data;
    end
  end

  always_comb begin
    rd_data = '0;
    for (int s = 0; s < SLOTS; s++)
      if (rd_slot == SW'(s)) rd_data = word_q[s];
  end
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
  import banked_rf_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        rd_a_idx,
  output logic [DATA_W-1:0] rd_a_data,
  input  logic [3:0]        rd_b_idx,
  output logic [DATA_W-1:0] rd_b_data,
  input  logic              wr_en,
  input  logic [3:0]        wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              st_rd_saved,
  output logic [DATA_W-1:0] st_rd_data,
  input  logic              st_wr_en,
  input  logic              st_wr_saved,
  input  logic [DATA_W-1:0] st_wr_data,
  input  logic              exc_en,
  input  logic [4:0]        exc_mode,
  output logic [DATA_W-1:0] pc_out,
  output logic [DATA_W-1:0] cpsr_out,
  output logic              spsr_fault
);
  localparam logic [DATA_W-1:0] RESET_STATUS = DATA_W'(MODE_SVC);

  logic [DATA_W-1:0] gpr_q [NUM_GPR];
  logic [DATA_W-1:0] pc_q;
  logic [DATA_W-1:0] cpsr_q;

  // Named internal events, also observed by the checker.
  bank_e             cur_bank;
  bank_e             exc_bank;
  logic              saved_ok;       // current mode owns a saved word
  logic              exc_saved_ok;   // target mode owns a saved word
  logic [DATA_W-1:0] spsr_cur;       // saved word of the current mode
  logic              sv_wr_en;
  logic [SLOT_W-1:0] sv_wr_slot;
  logic [DATA_W-1:0] sv_wr_data;

  always_comb begin
    cur_bank     = bank_of(cpsr_q[MODE_W-1:0]);
    exc_bank     = bank_of(exc_mode);
    saved_ok     = has_saved(cur_bank);
    exc_saved_ok = has_saved(exc_bank);
  end

  // Address mapping for the three general ports (R2, R3, R4).
  logic [GPR_IDX_W-1:0] a_phys, b_phys, w_phys;
  logic                 a_pc, b_pc, w_pc;

  rf_bank_map u_map_a (.idx(rd_a_idx), .bank(cur_bank), .phys(a_phys), .is_pc(a_pc));
  rf_bank_map u_map_b (.idx(rd_b_idx), .bank(cur_bank), .phys(b_phys), .is_pc(b_pc));
  rf_bank_map u_map_w (.idx(wr_idx),   .bank(cur_bank), .phys(w_phys), .is_pc(w_pc));

  // Combinational reads (R5, R6).
  assign rd_a_data = a_pc ? pc_q : gpr_q[a_phys];
  assign rd_b_data = b_pc ? pc_q : gpr_q[b_phys];

  // General and program counter storage; writes use the pre-edge mode (R11).
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_GPR; i++) gpr_q[i] <= '0;
      pc_q <= '0;
    end else if (wr_en) begin
      if (w_pc) pc_q <= wr_data;
      else      gpr_q[w_phys] <= wr_data;
    end
  end

  // Current status: exception entry wins over a status write (R7, R10, R11).
  always_ff @(posedge clk) begin
    if (!rst_n)
      cpsr_q <= RESET_STATUS;
    else if (exc_en)
      cpsr_q <= {cpsr_q[DATA_W-1:MODE_W], exc_mode};
    else if (st_wr_en && !st_wr_saved)
      cpsr_q <= st_wr_data;
  end

  // Saved status write selection (R8, R9, R10, R11).
  always_comb begin
    if (exc_en) begin
      sv_wr_en   = exc_saved_ok;
      sv_wr_slot = saved_slot(exc_bank);
      sv_wr_data = cpsr_q;
    end else begin
      sv_wr_en   = st_wr_en && st_wr_saved && saved_ok;
      sv_wr_slot = saved_slot(cur_bank);
      sv_wr_data = st_wr_data;
    end
  end

  rf_saved_bank #(.DATA_W(DATA_W), .SLOTS(NUM_SAVED)) u_saved (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (sv_wr_en),
    .wr_slot (sv_wr_slot),
    .wr_data (sv_wr_data),
    .rd_slot (saved_slot(cur_bank)),
    .rd_data (spsr_cur)
  );

  // Status read and illegal saved access flag (R9).
  assign st_rd_data = st_rd_saved ? (saved_ok ? spsr_cur : '0) : cpsr_q;
  assign spsr_fault = !saved_ok && (st_rd_saved || (st_wr_en && st_wr_saved));

  assign pc_out   = pc_q;
  assign cpsr_out = cpsr_q;

endmodule

// File: rtl/banked_regfile_chk.sv
module banked_regfile_chk
  import banked_rf_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [3:0]        rd_a_idx,
  input logic [DATA_W-1:0] rd_a_data,
  input logic              wr_en,
  input logic [3:0]        wr_idx,
  input logic [DATA_W-1:0] wr_data,
  input logic              st_rd_saved,
  input logic [DATA_W-1:0] st_rd_data,
  input logic              st_wr_en,
  input logic              st_wr_saved,
  input logic [DATA_W-1:0] st_wr_data,
  input logic              exc_en,
  input logic [4:0]        exc_mode,
  input logic [DATA_W-1:0] pc_out,
  input logic [DATA_W-1:0] cpsr_out,
  input logic              spsr_fault,
  input logic              saved_ok,
  input logic [DATA_W-1:0] spsr_cur
);

  assert_pc_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx == 4'd15) |=> pc_out == $past(wr_data));

  assert_pc_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_a_idx == 4'd15) |-> rd_a_data == pc_out);

  assert_status_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_wr_en && !st_wr_saved && !exc_en) |=> cpsr_out == $past(st_wr_data));

  assert_saved_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_wr_en && st_wr_saved && saved_ok && !exc_en) |=> spsr_cur == $past(st_wr_data));

  assert_fault_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!saved_ok && st_rd_saved) |-> (spsr_fault && st_rd_data == '0));

  assert_exc_mode_R10: assert property (@(posedge clk) disable iff (!rst_n)
    exc_en |=> cpsr_out[4:0] == $past(exc_mode));

  assert_exc_copy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_en && has_saved(bank_of(exc_mode))) |=> spsr_cur == $past(cpsr_out));

  assert_exc_priority_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_en && st_wr_en) |=> cpsr_out[DATA_W-1:5] == $past(cpsr_out[DATA_W-1:5]));

endmodule

bind banked_regfile banked_regfile_chk #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .rd_a_idx    (rd_a_idx),
  .rd_a_data   (rd_a_data),
  .wr_en       (wr_en),
  .wr_idx      (wr_idx),
  .wr_data     (wr_data),
  .st_rd_saved (st_rd_saved),
  .st_rd_data  (st_rd_data),
  .st_wr_en    (st_wr_en),
  .st_wr_saved (st_wr_saved),
  .st_wr_data  (st_wr_data),
  .exc_en      (exc_en),
  .exc_mode    (exc_mode),
  .pc_out      (pc_out),
  .cpsr_out    (cpsr_out),
  .spsr_fault  (spsr_fault),
  .saved_ok    (saved_ok),
  .spsr_cur    (spsr_cur)
);

// File: tb/banked_regfile_bench.sv
module banked_regfile_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  rd_a_idx, rd_b_idx, wr_idx;
  logic [31:0] rd_a_data, rd_b_data, wr_data;
  logic        wr_en, st_rd_saved, st_wr_en, st_wr_saved, exc_en;
  logic [31:0] st_rd_data, st_wr_data, pc_out, cpsr_out;
  logic [4:0]  exc_mode;
  logic        spsr_fault;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  banked_regfile u_banked_regfile (
    .clk(clk), .rst_n(rst_n),
    .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
    .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .st_rd_saved(st_rd_saved), .st_rd_data(st_rd_data),
    .st_wr_en(st_wr_en), .st_wr_saved(st_wr_saved), .st_wr_data(st_wr_data),
    .exc_en(exc_en), .exc_mode(exc_mode),
    .pc_out(pc_out), .cpsr_out(cpsr_out), .spsr_fault(spsr_fault)
  );

  localparam logic [4:0] M_USR = 5'h10, M_FIQ = 5'h11, M_IRQ = 5'h12, M_SVC = 5'h13,
                         M_ABT = 5'h17, M_UND = 5'h1B, M_SYS = 5'h1F;
  localparam logic [1:0] OP_MODE = 2'd0, OP_WR = 2'd1, OP_RD = 2'd2;

  // {op, logical index, data or expected value}; banking walk for R2, R3, R4.
  localparam int NV = 28;
  localparam logic [37:0] VEC [NV] = '{
    {OP_MODE, 4'd0,  32'(M_USR)},
    {OP_WR,   4'd0,  32'hA000_0000},
    {OP_WR,   4'd8,  32'hA000_0008},
    {OP_WR,   4'd13, 32'hA000_000D},
    {OP_WR,   4'd14, 32'hA000_000E},
    {OP_MODE, 4'd0,  32'(M_FIQ)},
    {OP_RD,   4'd0,  32'hA000_0000},
    {OP_RD,   4'd8,  32'h0},
    {OP_RD,   4'd13, 32'h0},
    {OP_WR,   4'd8,  32'hF000_0008},
    {OP_WR,   4'd13, 32'hF000_000D},
    {OP_MODE, 4'd0,  32'(M_IRQ)},
    {OP_RD,   4'd8,  32'hA000_0008},
    {OP_RD,   4'd13, 32'h0},
    {OP_WR,   4'd13, 32'h1000_000D},
    {OP_MODE, 4'd0,  32'(M_SYS)},
    {OP_RD,   4'd13, 32'hA000_000D},
    {OP_RD,   4'd14, 32'hA000_000E},
    {OP_MODE, 4'd0,  32'(M_FIQ)},
    {OP_RD,   4'd8,  32'hF000_0008},
    {OP_RD,   4'd13, 32'hF000_000D},
    {OP_MODE, 4'd0,  32'(M_UND)},
    {OP_WR,   4'd14, 32'hBB00_000E},
    {OP_MODE, 4'd0,  32'(M_ABT)},
    {OP_RD,   4'd14, 32'h0},
    {OP_MODE, 4'd0,  32'(M_IRQ)},
    {OP_RD,   4'd13, 32'h1000_000D},
    {OP_RD,   4'd0,  32'hA000_0000}
  };

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic set_mode(logic [31:0] word);
    st_wr_en = 1'b1; st_wr_saved = 1'b0; st_wr_data = word;
    tick();
    st_wr_en = 1'b0;
  endtask

  task automatic write_reg(logic [3:0] idx, logic [31:0] val);
    wr_en = 1'b1; wr_idx = idx; wr_data = val;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic write_saved(logic [31:0] val);
    st_wr_en = 1'b1; st_wr_saved = 1'b1; st_wr_data = val;
    tick();
    st_wr_en = 1'b0; st_wr_saved = 1'b0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; rd_a_idx = '0; rd_b_idx = '0; wr_en = 1'b0; wr_idx = '0; wr_data = '0;
    st_rd_saved = 1'b0; st_wr_en = 1'b0; st_wr_saved = 1'b0; st_wr_data = '0;
    exc_en = 1'b0; exc_mode = '0;
    repeat (3) tick();
    rst_n = 1'b1;
    #1;

    // R1: reset state
    check("R1 status", cpsr_out, 32'h0000_0013);
    check("R1 pc", pc_out, 32'h0);
    rd_a_idx = 4'd13; #1;
    check("R1 svc r13", rd_a_data, 32'h0);
    st_rd_saved = 1'b1; #1;
    check("R1 svc saved", st_rd_data, 32'h0);
    st_rd_saved = 1'b0;

    // Table walk: R2 R3 R4 banking
    for (int v = 0; v < NV; v++) begin
      case (VEC[v][37:36])
        OP_MODE: set_mode(VEC[v][31:0]);
        OP_WR:   write_reg(VEC[v][35:32], VEC[v][31:0]);
        default: begin
          rd_a_idx = VEC[v][35:32]; #1;
          check($sformatf("R2 R3 R4 vec%0d", v), rd_a_data, VEC[v][31:0]);
        end
      endcase
    end

    // R6: read during write returns old value, new value after the edge
    wr_en = 1'b1; wr_idx = 4'd1; wr_data = 32'h0000_0055; rd_b_idx = 4'd1; #1;
    check("R6 old value", rd_b_data, 32'h0);
    tick();
    wr_en = 1'b0; #1;
    check("R6 new value", rd_b_data, 32'h0000_0055);

    // R5: program counter shared, write visible next cycle
    wr_en = 1'b1; wr_idx = 4'd15; wr_data = 32'h0000_0100; #1;
    check("R5 pc before edge", pc_out, 32'h0);
    tick();
    wr_en = 1'b0;
    check("R5 pc after edge", pc_out, 32'h0000_0100);
    set_mode(32'(M_FIQ));
    rd_a_idx = 4'd15; rd_b_idx = 4'd15; #1;
    check("R5 r15 port A in FIQ", rd_a_data, 32'h0000_0100);
    check("R5 r15 port B in FIQ", rd_b_data, 32'h0000_0100);

    // R7: whole current status replaced
    set_mode(32'hF000_0012);
    check("R7 status word", cpsr_out, 32'hF000_0012);

    // R8: private saved words
    write_saved(32'h1111_1111);
    set_mode(32'(M_SVC));
    write_saved(32'h2222_2222);
    st_rd_saved = 1'b1; #1;
    check("R8 svc saved", st_rd_data, 32'h2222_2222);
    st_rd_saved = 1'b0;
    set_mode(32'(M_IRQ));
    st_rd_saved = 1'b1; #1;
    check("R8 irq saved", st_rd_data, 32'h1111_1111);
    st_rd_saved = 1'b0;

    // R9: no saved word in User or System
    set_mode(32'(M_USR));
    st_rd_saved = 1'b1; #1;
    check("R9 user read zero", st_rd_data, 32'h0);
    check("R9 user read fault", 32'(spsr_fault), 32'h1);
    st_rd_saved = 1'b0;
    st_wr_en = 1'b1; st_wr_saved = 1'b1; st_wr_data = 32'hDEAD_BEEF; #1;
    check("R9 user write fault", 32'(spsr_fault), 32'h1);
    tick();
    st_wr_en = 1'b0; st_wr_saved = 1'b0; #1;
    check("R9 fault clears", 32'(spsr_fault), 32'h0);
    set_mode(32'(M_SYS));
    st_rd_saved = 1'b1; #1;
    check("R9 system read zero", st_rd_data, 32'h0);
    check("R9 system fault", 32'(spsr_fault), 32'h1);
    st_rd_saved = 1'b0;
    set_mode(32'(M_IRQ));
    st_rd_saved = 1'b1; #1;
    check("R9 write discarded irq", st_rd_data, 32'h1111_1111);
    st_rd_saved = 1'b0;
    set_mode(32'(M_SVC));
    st_rd_saved = 1'b1; #1;
    check("R9 write discarded svc", st_rd_data, 32'h2222_2222);
    st_rd_saved = 1'b0;

    // R10: exception entry copies status and switches mode in one edge
    set_mode(32'hA000_0010);
    exc_en = 1'b1; exc_mode = M_ABT;
    tick();
    exc_en = 1'b0; #1;
    check("R10 new status", cpsr_out, 32'hA000_0017);
    st_rd_saved = 1'b1; #1;
    check("R10 saved copy", st_rd_data, 32'hA000_0010);
    check("R10 no fault", 32'(spsr_fault), 32'h0);
    st_rd_saved = 1'b0;

    // R11: exception entry with a status write and a register write in one cycle
    exc_en = 1'b1; exc_mode = M_UND;
    st_wr_en = 1'b1; st_wr_saved = 1'b0; st_wr_data = 32'h0000_0005;
    wr_en = 1'b1; wr_idx = 4'd13; wr_data = 32'h0000_0077;
    tick();
    exc_en = 1'b0; st_wr_en = 1'b0; wr_en = 1'b0; #1;
    check("R11 status write dropped", cpsr_out, 32'hA000_001B);
    st_rd_saved = 1'b1; #1;
    check("R11 und saved copy", st_rd_data, 32'hA000_0017);
    st_rd_saved = 1'b0;
    rd_a_idx = 4'd13; #1;
    check("R11 und r13 untouched", rd_a_data, 32'h0);
    set_mode(32'(M_ABT));
    rd_a_idx = 4'd13; #1;
    check("R11 abt r13 written", rd_a_data, 32'h0000_0077);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule